// File: doc/BRIEF.md
# Wake-Up Frame Pattern Filter

This block watches the byte stream of received Ethernet frames and flags those that match one programmed wake-up pattern. A 31-bit byte mask picks, out of a 31-byte window that begins at a programmable offset into the frame, which bytes enter a CRC-16. When the frame ends, the CRC is compared with a stored 16-bit value. The result is gated by an enable bit and by the destination address type: unicast or multicast.

Software programs four registers through a simple write port and can read them back. The receive path presents each byte with a valid strobe, plus start-of-frame and end-of-frame markers on the first and last byte. The filter answers with a single-cycle match pulse just after the last byte.

Top module: `wkup_pattern_filter`

## Requirements
- R1: Mask bit j (0..30) selects frame byte (effective offset + j) for the CRC. Bytes with a clear mask bit, bytes before the offset and bytes at or beyond offset + 31 do not enter the CRC.
- R2: Register map on the 2-bit address: 0 = byte mask, 1 = command, 2 = pattern offset (bits 7:0), 3 = expected CRC (bits 15:0). Reads return the stored values. Bit 31 of the mask register always reads 0, and writes to it are ignored.
- R3: Command bit 0 enables the filter. While it is 0, the match output stays low.
- R4: Command bit 3 selects the address type: 1 means only multicast frames match, 0 means only unicast frames match. A frame is multicast when bit 0 of its byte 0 is 1.
- R5: Command bits 31:4 and 2:1 are ignored on write and read as 0.
- R6: The offset counts from byte 0 of the frame, the first destination address byte. A programmed offset below 12 behaves exactly as offset 12.
- R7: The CRC starts at 0xFFFF on every start of frame. Each selected byte is fed LSB first: feedback = crc[15] xor data bit, crc = (crc << 1) xor (feedback ? 0x8005 : 0).
- R8: A frame matches when it is enabled, its address type fits, and its CRC equals the expected value at end of frame. The match output is high for exactly one clock, in the cycle after the end-of-frame byte is accepted.
- R9: A frame that ends before its window is complete is still judged on the CRC of the selected bytes received so far. This includes the case where no byte was selected and the CRC is 0xFFFF.
- R10: Cycles with valid low are ignored. An end-of-frame byte with no open frame (no start-of-frame since the last end of frame) never produces a match.
- R11: After reset, all registers read 0 and the match output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data, combinational |
| rx_valid_i | input | 1 | Byte valid |
| rx_sof_i | input | 1 | Marks the first byte of a frame |
| rx_eof_i | input | 1 | Marks the last byte of a frame |
| rx_data_i | input | 8 | Frame byte |
| match_o | output | 1 | Wake-up match pulse |

## Verification
The assertions check on every cycle that a match pulse follows an accepted end-of-frame byte of an open frame. They also check that the pulse only comes while the filter is enabled and the address type fits, that no byte below index 12 ever feeds the CRC, and that mask bit 31 reads as zero. Only the bench scenarios can show that the CRC value, the mask-to-byte mapping, the window edges, the offset clamp and the partial-window result are correct. For these, a behavioural model recomputes the expected match for every frame, and the bench compares it with the output on each clock.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
  localparam int MIN_OFF    = 12;
  localparam int CMD_EN_BIT = 0;
  localparam int CMD_MC_BIT = 3;
  localparam logic [15:0] CRC_POLY = 16'h8005;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_CMD  = 2'd1,
    REG_OFF  = 2'd2,
    REG_CRC  = 2'd3
  } reg_sel_e;

  // one byte, LSB first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/wkf_regs.sv
module wkf_regs
  import wkf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WIN_LEN = 31,
  parameter int OFF_W = 8,
  parameter int CRC_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [1:0]         rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [WIN_LEN-1:0] mask_o,
  output logic               en_o,
  output logic               mc_sel_o,
  output logic [OFF_W-1:0]   off_o,
  output logic [CRC_W-1:0]   crc_o
);
  logic [WIN_LEN-1:0] mask_q;
  logic               en_q, mc_q;
  logic [OFF_W-1:0]   off_q;
  logic [CRC_W-1:0]   crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      en_q   <= 1'b0;
      mc_q   <= 1'b0;
      off_q  <= '0;
      crc_q  <= '0;
    end else if (wr_en_i) begin
      unique case (reg_sel_e'(wr_addr_i))
        REG_MASK: mask_q <= wr_data_i[WIN_LEN-1:0];
        REG_CMD: begin
          en_q <= wr_data_i[CMD_EN_BIT];
          mc_q <= wr_data_i[CMD_MC_BIT];
        end
        REG_OFF:  off_q <= wr_data_i[OFF_W-1:0];
        REG_CRC:  crc_q <= wr_data_i[CRC_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (reg_sel_e'(rd_addr_i))
      REG_MASK: rd_data_o[WIN_LEN-1:0] = mask_q;
      REG_CMD: begin
        rd_data_o[CMD_EN_BIT] = en_q;
        rd_data_o[CMD_MC_BIT] = mc_q;
      end
      REG_OFF:  rd_data_o[OFF_W-1:0] = off_q;
      REG_CRC:  rd_data_o[CRC_W-1:0] = crc_q;
      default: ;
    endcase
  end

  assign mask_o   = mask_q;
  assign en_o     = en_q;
  assign mc_sel_o = mc_q;
  assign off_o    = off_q;
  assign crc_o    = crc_q;
endmodule

// File: rtl/wkf_window.sv
module wkf_window
  import wkf_pkg::*;
#(
  parameter int WIN_LEN = 31,
  parameter int OFF_W = 8,
  localparam int IDX_W = $clog2((2 ** OFF_W) + WIN_LEN + 1),
  localparam int REL_W = $clog2(WIN_LEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               sof_i,
  input  logic               eof_i,
  input  logic [7:0]         data_i,
  input  logic [WIN_LEN-1:0] mask_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic               step_o,
  output logic               first_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               mc_now_o,
  output logic               frame_ok_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0]      cnt_q, idx, eff_off, rel;
  logic [2**REL_W-1:0]   mask_pad;
  logic                  in_frame_q, mc_q, in_win;

  assign idx     = sof_i ? '0 : cnt_q;
  // offsets below the address fields are clamped
  assign eff_off = (off_i < OFF_W'(MIN_OFF)) ? IDX_W'(MIN_OFF) : IDX_W'(off_i);
  assign rel     = idx - eff_off;
  assign in_win  = (idx >= eff_off) && (rel < IDX_W'(WIN_LEN));

  always_comb begin
    mask_pad = '0;
    mask_pad[WIN_LEN-1:0] = mask_i;
  end

  assign step_o     = valid_i && in_win && mask_pad[rel[REL_W-1:0]];
  assign first_o    = valid_i && sof_i;
  assign idx_o      = idx;
  assign mc_now_o   = sof_i ? data_i[0] : mc_q;
  assign frame_ok_o = sof_i || in_frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      mc_q       <= 1'b0;
    end else if (valid_i) begin
      cnt_q <= (idx == IDX_MAX) ? idx : idx + 1'b1;
      if (eof_i)      in_frame_q <= 1'b0;
      else if (sof_i) in_frame_q <= 1'b1;
      if (sof_i) mc_q <= data_i[0];
    end
  end
endmodule

// File: rtl/wkf_crc16.sv
module wkf_crc16
  import wkf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        first_i,
  input  logic        step_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_next_o
);
  logic [15:0] crc_q, crc_cur;

  assign crc_cur    = first_i ? CRC_INIT : crc_q;
  assign crc_next_o = step_i ? crc16_byte(crc_cur, data_i) : crc_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_INIT;
    else if (valid_i) crc_q <= crc_next_o;
  end
endmodule

// File: rtl/wkup_pattern_filter.sv
module wkup_pattern_filter
  import wkf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WIN_LEN = 31,
  parameter int OFF_W = 8,
  localparam int CRC_W = 16,
  localparam int IDX_W = $clog2((2 ** OFF_W) + WIN_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [7:0]        rx_data_i,
  output logic              match_o
);
  logic [WIN_LEN-1:0] mask;
  logic               en_q, mc_sel;
  logic [OFF_W-1:0]   off;
  logic [CRC_W-1:0]   crc_exp, crc_next;
  logic               crc_step, first, mc_now, frame_ok, match_q;
  logic [IDX_W-1:0]   byte_idx;

  wkf_regs #(.DATA_W(DATA_W), .WIN_LEN(WIN_LEN), .OFF_W(OFF_W), .CRC_W(CRC_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .mask_o(mask), .en_o(en_q), .mc_sel_o(mc_sel), .off_o(off), .crc_o(crc_exp)
  );

  wkf_window #(.WIN_LEN(WIN_LEN), .OFF_W(OFF_W)) u_win (
    .clk_i, .rst_ni,
    .valid_i(rx_valid_i), .sof_i(rx_sof_i), .eof_i(rx_eof_i), .data_i(rx_data_i),
    .mask_i(mask), .off_i(off),
    .step_o(crc_step), .first_o(first), .idx_o(byte_idx),
    .mc_now_o(mc_now), .frame_ok_o(frame_ok)
  );

  wkf_crc16 u_crc (
    .clk_i, .rst_ni, .valid_i(rx_valid_i), .first_i(first), .step_i(crc_step),
    .data_i(rx_data_i), .crc_next_o(crc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else match_q <= rx_valid_i && rx_eof_i && frame_ok && en_q &&
                    (mc_now == mc_sel) && (crc_next == crc_exp);
  end

  assign match_o = match_q;
endmodule

// File: rtl/wkup_pattern_filter_chk.sv
module wkup_pattern_filter_chk
  import wkf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic              rx_eof_i,
  input logic              match_o,
  input logic              en_q,
  input logic              mc_now,
  input logic              mc_sel,
  input logic              frame_ok,
  input logic              crc_step,
  input logic [IDX_W-1:0]  byte_idx,
  input logic [1:0]        rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o
);
  // R8
  pulse_after_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(rx_valid_i && rx_eof_i));
  // R3
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(en_q));
  // R4
  addr_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(mc_now == mc_sel));
  // R10
  open_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(frame_ok));
  // R6
  min_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_step |-> (byte_idx >= IDX_W'(MIN_OFF)));
  // R2
  mask_top_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == REG_MASK) |-> !rd_data_o[31]);
endmodule

bind wkup_pattern_filter wkup_pattern_filter_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .rx_valid_i, .rx_eof_i, .match_o, .en_q, .mc_now, .mc_sel,
  .frame_ok, .crc_step, .byte_idx, .rd_addr_i, .rd_data_o
);

// File: tb/wkup_pattern_filter_test.sv
`timescale 1ns/100ps
module wkup_pattern_filter_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        valid = 1'b0, sof = 1'b0, eof = 1'b0, match;
  logic [7:0]  data = '0;

  int checks = 0, failures = 0, pulse_cnt = 0;
  string cur_req = "R11";

  always #2.5 clk = ~clk;

  wkup_pattern_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rx_valid_i(valid), .rx_sof_i(sof),
    .rx_eof_i(eof), .rx_data_i(data), .match_o(match)
  );

  // reference CRC per R7 / window per R1, R6
  function automatic int ref_crc(input byte unsigned q[$], input int mask, input int off);
    int c = 16'hFFFF;
    int eo = (off < 12) ? 12 : off;
    for (int i = 0; i < q.size(); i++) begin
      int j = i - eo;
      if (j >= 0 && j < 31 && ((mask >> j) & 1)) begin
        for (int b = 0; b < 8; b++) begin
          int fb = ((c >> 15) & 1) ^ ((q[i] >> b) & 1);
          c = (c << 1) & 16'hFFFF;
          if (fb != 0) c = c ^ 16'h8005;
        end
      end
    end
    return c;
  endfunction

  // model registers and frame state
  int m_mask = 0, m_off = 0, m_crc = 0;
  bit m_en = 0, m_mc = 0, m_in = 0, exp_match = 0;
  byte unsigned mq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_off = 0; m_crc = 0; m_en = 0; m_mc = 0; m_in = 0;
      mq.delete();
      exp_match <= 1'b0;
    end else begin
      if (valid) begin
        if (sof) begin mq.delete(); m_in = 1; end
        if (m_in) mq.push_back(data);
        if (eof) begin
          exp_match <= m_in && m_en && (mq[0][0] == m_mc) &&
                       (ref_crc(mq, m_mask, m_off) == m_crc);
          m_in = 0;
        end else exp_match <= 1'b0;
      end else exp_match <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_mask = int'(wr_data & 32'h7FFF_FFFF);
          2'd1: begin m_en = wr_data[0]; m_mc = wr_data[3]; end
          2'd2: m_off = int'(wr_data[7:0]);
          default: m_crc = int'(wr_data[15:0]);
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (match !== exp_match) begin
        failures++;
        $display("FAIL %s cycle compare: match actual=%0b expected=%0b", cur_req, match, exp_match);
      end
      if (match) pulse_cnt++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input int a, input int exp);
    @(negedge clk);
    rd_addr = 2'(a);
    #0.5;
    check(req, "register read", int'(rd_data), exp);
  endtask

  byte unsigned tx[$];

  task automatic mk_frame(input int len, input int seed, input bit mc);
    tx.delete();
    for (int i = 0; i < len; i++) begin
      byte unsigned b = byte'((i * 29 + seed * 7 + i * i) & 8'hFF);
      if (i == 0) b[0] = mc;
      tx.push_back(b);
    end
  endtask

  task automatic send(input bit with_sof, input bit gaps);
    for (int i = 0; i < tx.size(); i++) begin
      @(negedge clk);
      valid = 1'b1; data = tx[i];
      sof = with_sof && (i == 0);
      eof = (i == tx.size() - 1);
      if (gaps && (i % 2 == 1)) begin
        @(negedge clk);
        valid = 1'b0; data = 8'hA5; sof = 1'b1; eof = 1'b1;
      end
    end
    @(negedge clk);
    valid = 1'b0; sof = 1'b0; eof = 1'b0;
  endtask

  task automatic run(input string req, input string what, input int exp_pulses,
                     input bit with_sof, input bit gaps);
    cur_req = req;
    pulse_cnt = 0;
    send(with_sof, gaps);
    repeat (3) @(negedge clk);
    check(req, what, pulse_cnt, exp_pulses);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int mk, pc;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "match in reset", int'(match), 0);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) rd("R11", a, 0);

    // R2 mask bit 31 dropped, R5 reserved command bits
    wr(0, 32'hFFFF_FFFF);
    rd("R2", 0, 32'h7FFF_FFFF);
    wr(1, 32'hFFFF_FFF6);
    rd("R5", 1, 32'h0000_0000);
    wr(1, 32'hFFFF_FFFF);
    rd("R5", 1, 32'h0000_0009);
    wr(2, 32'hFFFF_FF33);
    rd("R2", 2, 32'h33);
    wr(3, 32'hABCD_1234);
    rd("R2", 3, 32'h1234);

    // R8, R7: unicast match with sparse mask at offset 14
    mk = 32'h2A5C_93E1;
    wr(0, mk); wr(2, 14); wr(1, 32'h1);
    mk_frame(64, 1, 1'b0);
    pc = ref_crc(tx, mk, 14);
    wr(3, pc);
    run("R8", "unicast pattern hit", 1, 1, 0);
    // R7 CRC restarts on each frame
    run("R7", "same frame again", 1, 1, 0);
    // R8 wrong expected value
    wr(3, pc ^ 1);
    run("R8", "crc mismatch", 0, 1, 0);
    wr(3, pc);

    // R1 byte with clear mask bit (bit 0 of 0x...E1 is set, bit 1 clear) does not matter
    tx[15] = tx[15] ^ 8'hFF;
    run("R1", "unmasked byte changed", 1, 1, 0);
    tx[14] = tx[14] ^ 8'h01;
    run("R1", "masked byte changed", 0, 1, 0);

    // R1 window edges with full mask at offset 20
    mk = 32'h7FFF_FFFF;
    wr(0, mk); wr(2, 20);
    mk_frame(70, 2, 1'b0);
    wr(3, ref_crc(tx, mk, 20));
    run("R1", "full window hit", 1, 1, 0);
    tx[51] = tx[51] ^ 8'h5A;
    tx[19] = tx[19] ^ 8'h3C;
    run("R1", "bytes outside window changed", 1, 1, 0);
    tx[50] = tx[50] ^ 8'h01;
    run("R1", "last window byte changed", 0, 1, 0);

    // R4 address type
    mk_frame(60, 3, 1'b1);
    wr(2, 12);
    wr(3, ref_crc(tx, mk, 12));
    run("R4", "multicast frame, unicast type", 0, 1, 0);
    wr(1, 32'h9);
    run("R4", "multicast frame, multicast type", 1, 1, 0);
    tx[0][0] = 1'b0;
    run("R4", "unicast frame, multicast type", 0, 1, 0);
    tx[0][0] = 1'b1;

    // R3 disabled
    wr(1, 32'h8);
    run("R3", "disabled filter", 0, 1, 0);
    wr(1, 32'h9);

    // R6 offset clamp: offset 5 behaves like 12
    wr(2, 5);
    run("R6", "offset 5 as 12", 1, 1, 0);
    wr(2, 0);
    run("R6", "offset 0 as 12", 1, 1, 0);

    // R9 short frames
    wr(1, 32'h1); wr(2, 30);
    mk_frame(33, 4, 1'b0);
    wr(3, ref_crc(tx, mk, 30));
    run("R9", "frame ends inside window", 1, 1, 0);
    mk_frame(10, 5, 1'b0);
    wr(3, 32'hFFFF);
    run("R9", "frame ends before window", 1, 1, 0);

    // R10 valid gaps and orphan end of frame
    mk_frame(48, 6, 1'b0);
    wr(2, 12);
    wr(3, ref_crc(tx, mk, 12));
    run("R10", "frame with idle gaps", 1, 1, 1);
    wr(0, 0); wr(3, 32'hFFFF);
    mk_frame(5, 7, 1'b0);
    run("R10", "empty mask short frame", 1, 1, 0);
    run("R10", "end without start", 0, 0, 0);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule